// File: doc/BRIEF.md
# Atomic Set/Clear GPIO Register Bank

A 32-pin general-purpose I/O controller organised as two banks of 16 pins. Software reaches it through a simple 32-bit register port (address, write strobe, write data, read strobe, read data). Every per-pin control register is changed by one atomic command word. Ones in the lower half set bits. Ones in the upper half clear bits. Because of this, two agents can change different pins without any read-modify-write sequence between them.

Each bank holds these registers:
- output value
- output enable
- input enable
- two output auxiliary selects
- one input auxiliary select
- a rising-edge status register
- a falling-edge status register
- a read-only level register

Each pin input passes through a two-flop synchronizer. Edges are latched only while that pin's input is enabled. A status bit is cleared by writing a 1 to it.

Pins 23, 29, 30 and 31 do not exist. Their bits are held at zero in every register and on every output.

Top module: `gpio_setclr_bank`

## Requirements
- R1: Address map. Address bit 7 selects the bank: 0 for pins 0-15, 1 for pins 16-31, so the high bank sits 0x80 above the low bank. Word offsets within a bank are: 0x00 output value, 0x04 output enable, 0x08 input enable, 0x0C output select A, 0x10 output select B, 0x14 input select, 0x18 rising-edge status, 0x1C falling-edge status, 0x20 level. A read returns the register in bits 15:0 of `bus_rdata`, with bits 31:16 zero, on the clock edge that samples `bus_rd`.
- R2: On a write to a control register (offsets 0x00 to 0x14), a 1 in data bit n (0 to 15) sets the bit for pin n of that bank.
- R3: On the same kind of write, a 1 in data bit n+16 clears the bit for pin n. A pin whose bits n and n+16 are both 0 keeps its value.
- R4: When bits n and n+16 are both 1 in one write, the pin's control bit ends at 0 (clear wins).
- R5: Edge status registers ignore data bits 31:16. A 1 in data bit n clears the latched status of pin n, and a 0 leaves it unchanged.
- R6: An edge detected in the same cycle as a write that clears that pin's status leaves the status bit at 1.
- R7: Pins 23, 29, 30 and 31 read 0 in every register, and drive 0 on `pin_oe`, `pin_out` and the select outputs, whatever is written to them.
- R8: `pin_oe` equals the output-enable register. `pin_out` carries the output value only where output enable is 1, and is 0 elsewhere.
- R9: Input levels pass through two synchronizing flops. The level register and edge detection see a pin only while its input-enable bit is 1; for a disabled pin the level reads 0 and no edge is latched.
- R10: After reset every control bit, status bit and output is 0.
- R11: `sel_out_a`, `sel_out_b` and `sel_in` carry the contents of the two output select registers and the input select register of both banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; the set half is bits 15:0, the clear half is bits 31:16 |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Output value, gated by output enable |
| pin_oe | output | 32 | Output enable per pin |
| sel_out_a | output | 32 | Output select A per pin |
| sel_out_b | output | 32 | Output select B per pin |
| sel_in | output | 32 | Input select per pin |

## Verification
The results fall due at different times:
- A write changes a control register and the pin outputs at the clock edge that samples the strobe.
- A read shows the register in `bus_rdata` after the edge that samples `bus_rd`.
- A pin change becomes visible in the level register two edges after it is applied.
- A pin change is latched as an edge three edges after it is applied.

The bench drives inputs on falling clock edges and samples outputs after the following rising edge. It waits several cycles after changing pins before it reads. The edge-versus-clear collision is timed exactly: the pin changes two falling edges before the clearing write is driven, so the write and the detected edge meet at the same rising edge.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
    localparam int BANK_W  = 16;
    localparam int NUM_CTL = 6;

    typedef enum logic [3:0] {
        RG_OUT  = 4'd0,
        RG_OE   = 4'd1,
        RG_IE   = 4'd2,
        RG_OSA  = 4'd3,
        RG_OSB  = 4'd4,
        RG_ISA  = 4'd5,
        RG_RISE = 4'd6,
        RG_FALL = 4'd7,
        RG_LVL  = 4'd8
    } reg_e;

    localparam int LAST_REG = 8;
endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_in,
    input  logic [N-1:0] en,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl  = st_q.s2 & en;
    assign rise = en & st_q.s2 & ~st_q.prev;
    assign fall = en & ~st_q.s2 & st_q.prev;

    // R9: an edge is only reported on an enabled pin
    p_edge_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise | fall) & ~en) == '0);
endmodule

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank
    import gpio_sc_pkg::*;
#(
    parameter int           W    = 16,
    parameter logic [W-1:0] RSVD = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  reg_e           sel,
    input  logic [2*W-1:0] wdata,
    input  logic [W-1:0]   lvl,
    input  logic [W-1:0]   rise_in,
    input  logic [W-1:0]   fall_in,
    output logic [W-1:0]   out_val,
    output logic [W-1:0]   oe,
    output logic [W-1:0]   ie,
    output logic [W-1:0]   osa,
    output logic [W-1:0]   osb,
    output logic [W-1:0]   isa,
    output logic [W-1:0]   rdata
);
    typedef struct packed {
        logic [NUM_CTL-1:0][W-1:0] ctl;
        logic [W-1:0]              rise;
        logic [W-1:0]              fall;
    } bank_t;

    bank_t bk_d, bk_q;

    logic [W-1:0] set_v, clr_v, keep;
    assign set_v = wdata[W-1:0];
    assign clr_v = wdata[2*W-1:W];
    assign keep  = ~RSVD;

    always_comb begin
        bk_d = bk_q;
        for (int k = 0; k < NUM_CTL; k++) begin
            if (wr_en && (int'(sel) == k))
                bk_d.ctl[k] = (bk_q.ctl[k] | set_v) & ~clr_v & keep;
        end
        bk_d.rise = ((bk_q.rise & ~((wr_en && sel == RG_RISE) ? set_v : '0))
                     | rise_in) & keep;
        bk_d.fall = ((bk_q.fall & ~((wr_en && sel == RG_FALL) ? set_v : '0))
                     | fall_in) & keep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign out_val = bk_q.ctl[RG_OUT];
    assign oe      = bk_q.ctl[RG_OE];
    assign ie      = bk_q.ctl[RG_IE];
    assign osa     = bk_q.ctl[RG_OSA];
    assign osb     = bk_q.ctl[RG_OSB];
    assign isa     = bk_q.ctl[RG_ISA];

    always_comb begin
        case (sel)
            RG_RISE: rdata = bk_q.rise;
            RG_FALL: rdata = bk_q.fall;
            RG_LVL:  rdata = lvl & keep;
            default: rdata = (int'(sel) < NUM_CTL) ? bk_q.ctl[sel] : '0;
        endcase
    end

    // R2: requested set bits without matching clear end up at 1
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RG_OUT) |=>
        ((out_val & $past(set_v & ~clr_v & keep)) == $past(set_v & ~clr_v & keep)));
    // R3/R4: any bit named in the clear half ends at 0, even when also set
    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RG_OE) |=> ((oe & $past(clr_v)) == '0));
    // R6: a freshly detected edge is never lost
    p_edge_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bk_q.rise & $past(rise_in & keep)) == $past(rise_in & keep)));
    // R5: without a new edge, write-one clears the status
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RG_FALL && fall_in == '0) |=> ((bk_q.fall & $past(set_v)) == '0));
    // R7: reserved pins never hold state
    p_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_val | oe | ie | bk_q.rise | bk_q.fall) & RSVD) == '0);
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
    import gpio_sc_pkg::*;
#(
    parameter int          NUM_BANKS    = 2,
    parameter int          BANK_STRIDE  = 128,
    parameter logic [31:0] RSVD_MASK    = 32'hE080_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    input  logic [31:0] pin_in,
    output logic [31:0] pin_out,
    output logic [31:0] pin_oe,
    output logic [31:0] sel_out_a,
    output logic [31:0] sel_out_b,
    output logic [31:0] sel_in
);
    localparam int W          = BANK_W;
    localparam int NPINS      = NUM_BANKS * W;
    localparam int BANK_SHIFT = $clog2(BANK_STRIDE);
    localparam int BANK_BITS  = $clog2(NUM_BANKS);
    localparam int IDX_W      = BANK_SHIFT - 2;

    logic [BANK_BITS-1:0] bank_idx;
    logic [IDX_W-1:0]     reg_idx;
    logic                 addr_ok;
    reg_e                 sel;

    assign bank_idx = bus_addr[BANK_SHIFT +: BANK_BITS];
    assign reg_idx  = bus_addr[BANK_SHIFT-1:2];
    assign addr_ok  = (bus_addr[1:0] == 2'b00) && (int'(reg_idx) <= LAST_REG);
    assign sel      = addr_ok ? reg_e'(reg_idx[3:0]) : RG_LVL;

    logic [NPINS-1:0] ie_all, lvl_all, rise_all, fall_all, val_all;
    logic [NUM_BANKS-1:0][W-1:0] bk_rdata;

    gpio_sc_sync #(.N(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (pin_in),
        .en     (ie_all),
        .lvl    (lvl_all),
        .rise   (rise_all),
        .fall   (fall_all)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_b;
        assign wr_b = bus_wr && addr_ok && (int'(bank_idx) == b);
        gpio_sc_bank #(.W(W), .RSVD(RSVD_MASK[b*W +: W])) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_b),
            .sel     (sel),
            .wdata   (bus_wdata),
            .lvl     (lvl_all[b*W +: W]),
            .rise_in (rise_all[b*W +: W]),
            .fall_in (fall_all[b*W +: W]),
            .out_val (val_all[b*W +: W]),
            .oe      (pin_oe[b*W +: W]),
            .ie      (ie_all[b*W +: W]),
            .osa     (sel_out_a[b*W +: W]),
            .osb     (sel_out_b[b*W +: W]),
            .isa     (sel_in[b*W +: W]),
            .rdata   (bk_rdata[b])
        );
    end

    assign pin_out = val_all & pin_oe;

    typedef struct packed {
        logic [31:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (bus_rd)
            rd_d.rdata = addr_ok ? {16'h0, bk_rdata[bank_idx]} : 32'h0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    // R8: nothing is driven on a pin whose output is disabled
    p_drive_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);
    // R1: upper half of read data is always zero
    p_rd_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0);
    // R7: reserved pins never drive
    p_rsvd_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe | sel_out_a | sel_out_b | sel_in) & RSVD_MASK) == '0);
endmodule

// File: tb/gpio_setclr_bank_test.sv
module gpio_setclr_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, sel_out_a, sel_out_b, sel_in;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] A_OUT = 8'h00, A_OE = 8'h04, A_IE = 8'h08, A_OSA = 8'h0C,
                           A_OSB = 8'h10, A_ISA = 8'h14, A_RISE = 8'h18,
                           A_FALL = 8'h1C, A_LVL = 8'h20, HI = 8'h80;

    gpio_setclr_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .sel_out_a(sel_out_a), .sel_out_b(sel_out_b), .sel_in(sel_in)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int k = 0; k < 9; k++) begin
            rd(8'(k * 4), d);        check("R10 low reg", d, 32'h0);
            rd(HI | 8'(k * 4), d);   check("R10 high reg", d, 32'h0);
        end
        check("R10 pin_oe", pin_oe, 32'h0);
        check("R10 pin_out", pin_out, 32'h0);
        check("R10 sel", sel_out_a | sel_out_b | sel_in, 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        wr(A_OUT, 32'h0000_00FF); rd(A_OUT, d); check("R2 set", d, 32'h0000_00FF);
        wr(A_OUT, 32'h000F_0000); rd(A_OUT, d); check("R3 clear", d, 32'h0000_00F0);
        wr(A_OUT, 32'h0000_0000); rd(A_OUT, d); check("R3 zero keeps", d, 32'h0000_00F0);
        rd(HI | A_OUT, d); check("R1 other bank untouched", d, 32'h0);
    endtask

    task automatic t_clear_priority();
        logic [31:0] d;
        wr(A_OUT, 32'h0030_0030); rd(A_OUT, d); check("R4 set+clear on 1", d, 32'h0000_00C0);
        wr(A_OUT, 32'h0001_0001); rd(A_OUT, d); check("R4 set+clear on 0", d, 32'h0000_00C0);
    endtask

    task automatic t_high_bank();
        logic [31:0] d;
        wr(HI | A_OUT, 32'h0000_FFFF); rd(HI | A_OUT, d);
        check("R1 R7 high bank set", d, 32'h0000_1F7F);
        rd(A_OUT, d); check("R1 low bank untouched", d, 32'h0000_00C0);
    endtask

    task automatic t_pins();
        wr(A_OE, 32'h0000_00F0);
        check("R8 pin_oe low", {16'h0, pin_oe[15:0]}, 32'h0000_00F0);
        check("R8 pin_out low", {16'h0, pin_out[15:0]}, 32'h0000_00C0);
        check("R8 pin_out high disabled", {16'h0, pin_out[31:16]}, 32'h0);
        wr(A_OE, 32'h0080_0000);
        check("R8 pin_out after oe clear", {16'h0, pin_out[15:0]}, 32'h0000_0040);
        wr(HI | A_OE, 32'h0000_FFFF);
        check("R7 R8 pin_oe high", {16'h0, pin_oe[31:16]}, 32'h0000_1F7F);
        check("R7 R8 pin_out high", {16'h0, pin_out[31:16]}, 32'h0000_1F7F);
        wr(A_OSA, 32'h0000_1234); wr(A_OSB, 32'h0000_8001); wr(HI | A_ISA, 32'h0000_FFFF);
        check("R11 sel_out_a", sel_out_a, 32'h0000_1234);
        check("R11 sel_out_b", sel_out_b, 32'h0000_8001);
        check("R11 R7 sel_in", sel_in, 32'h1F7F_0000);
    endtask

    task automatic t_input();
        logic [31:0] d;
        wr(A_IE, 32'h0000_000F);
        @(negedge clk); pin_in = 32'h0000_0113;
        repeat (4) @(negedge clk);
        rd(A_LVL, d);  check("R9 level gated", d, 32'h0000_0003);
        rd(A_RISE, d); check("R9 rise latched", d, 32'h0000_0003);
        rd(A_FALL, d); check("R9 no fall", d, 32'h0);
        @(negedge clk); pin_in = 32'h0;
        repeat (4) @(negedge clk);
        rd(A_FALL, d); check("R9 fall latched", d, 32'h0000_0003);
        rd(A_RISE, d); check("R9 rise stays", d, 32'h0000_0003);
        wr(HI | A_IE, 32'h0000_FFFF);
        @(negedge clk); pin_in = 32'hFFFF_0000;
        repeat (4) @(negedge clk);
        rd(HI | A_LVL, d); check("R7 R9 high level", d, 32'h0000_1F7F);
        rd(HI | A_RISE, d); check("R7 high rise", d, 32'h0000_1F7F);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(A_RISE, 32'h0000_0001); rd(A_RISE, d); check("R5 w1c", d, 32'h0000_0002);
        wr(A_RISE, 32'hFFFF_0000); rd(A_RISE, d); check("R5 high half ignored", d, 32'h0000_0002);
        wr(A_FALL, 32'h0000_0003); rd(A_FALL, d); check("R5 fall cleared", d, 32'h0);
        wr(A_RISE, 32'h0000_FFFF); rd(A_RISE, d); check("R5 all cleared", d, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        @(negedge clk); pin_in[0] = 1'b1;
        @(negedge clk);
        wr(A_RISE, 32'h0000_0001);
        rd(A_RISE, d); check("R6 edge beats clear", d, 32'h0000_0001);
        wr(A_RISE, 32'h0000_0001);
        rd(A_RISE, d); check("R6 later clear works", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_clear();
        t_clear_priority();
        t_high_bank();
        t_pins();
        t_input();
        t_w1c();
        t_collision();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule